// File: doc/BRIEF.md
# Key-Cleared Watchdog Timer

This block is a memory-mapped watchdog timer. A slow input clock passes through a fixed divide-by-32 prescaler and then into a postscaled counter. The terminal count is 2^ps prescaled ticks, where ps is a 5-bit field in the control word. When the counter reaches its terminal count, the block:

- emits a one-cycle reset request,
- sets a sticky timeout flag in a reset-cause word,
- starts counting again from zero.

Software keeps the system alive by writing a fixed 16-bit key, 0x5743, into the upper half of the control word. No other write restarts the count.

The control word can be written directly. It can also be modified through a bit-clear alias and a bit-set alias. An optional windowed mode treats a key that arrives too early as a fault. In the cycle right after the enable bit drops, every register access is blanked.

Top module: `wdt_key_timer`

## Requirements
- R1: After reset, the control word reads back with enable 0, ps 0 and window 0. The reset-cause word reads 0 and `wdt_rst_req` is low.
- R2: While the enable bit (control bit 15) is 0, both counters hold at zero and no reset request occurs.
- R3: Once enabled, `wdt_rst_req` goes high for exactly one cycle, 32·2^ps clock edges after the edge that enabled the block or last cleared the count. The count then restarts from zero, so the next pulse follows after the same interval.
- R4: A write to address 0x0 with byte strobes 4'b1100 and data bits 31:16 equal to 0x5743 clears both counters. Any other value in that half-word leaves the count running.
- R5: Reset-cause bit 4, at address 0xC, is set by every reset request and stays set. A write to 0xC with strobe bit 0 set and data bit 4 set clears it. A set on the same edge wins over the clear.
- R6: A write to 0x4 clears, and a write to 0x8 sets, exactly those control bits among 15, 12:8 and 0 whose data bit is 1. Byte strobes are ignored for both aliases.
- R7: Control bits 7:6 always read back the value of `clk_src_id`. Writes never change them.
- R8: In the cycle right after the enable bit goes from 1 to 0, reads return 0 and writes have no effect.
- R9: When the window bit (control bit 0) is 1 and ps ≥ 2, a key is accepted only when the post count is at least 3/4 of 2^ps. A key before that point makes `wdt_rst_req` pulse on the next edge, sets the cause flag and clears the count. For ps < 2 the window is always open.
- R10: A write to 0x0 with strobe bit 1 updates the enable bit and the ps field (bits 12:8), and strobe bit 0 updates the window bit. The unused control bits and cause bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the watchdog count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_src_id | input | 2 | Read-only clock-source identifier reflected in bits 7:6 |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 4 | Byte address: 0x0 control, 0x4 clear alias, 0x8 set alias, 0xC cause |
| bus_strb | input | 4 | Byte enables for writes to 0x0 and 0xC |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
Register writes, key clears, cause-flag updates and early-key resets all take effect on the edge that captures the write, and show at the ports right after that edge. Read data is combinational from registered state and shows in the same cycle. A timeout pulse shows right after edge 32·2^ps, counted from the capturing edge of the enable or key write.

The bench drives every input on the falling edge and samples every output one falling edge later or more. It counts edges from each write to decide exactly which sample must show the pulse. It also checks that the request stays low at every sample before that edge and clears at the sample after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [15:0] WDT_KEY      = 16'h5743;
    localparam int          EN_BIT       = 15;
    localparam int          PS_LSB       = 8;
    localparam int          ID_LSB       = 6;
    localparam int          WIN_BIT      = 0;
    localparam int          FLAG_BIT     = 4;
    localparam logic [1:0]  SEL_CTRL     = 2'd0;
    localparam logic [1:0]  SEL_CLR      = 2'd1;
    localparam logic [1:0]  SEL_SET      = 2'd2;
    localparam logic [1:0]  SEL_CAUSE    = 2'd3;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int PS_W = 5,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [3:0]      strb,
    input  logic [31:0]     wdata,
    input  logic [1:0]      src_id,
    input  logic            timeout_evt,
    output logic [31:0]     rdata,
    output logic            en,
    output logic            win,
    output logic [PS_W-1:0] ps,
    output logic            flag,
    output logic            key_hit
);
    typedef struct packed {
        logic            en;
        logic            win;
        logic [PS_W-1:0] ps;
        logic            flag;
        logic            blank;
    } reg_state_t;

    reg_state_t q, d;
    logic [1:0] sel;
    logic       wr_ok;
    logic       unused_bits;

    assign sel         = addr[3:2];
    assign wr_ok       = we && !q.blank;
    assign unused_bits = ^{addr[1:0], wdata[14:PS_LSB+PS_W], wdata[PS_LSB-1:5], wdata[3:1]};

    always_comb begin
        d       = q;
        d.blank = 1'b0;
        key_hit = 1'b0;
        if (wr_ok) begin
            case (sel)
                SEL_CTRL: begin
                    if (strb[1]) begin
                        d.en = wdata[EN_BIT];
                        d.ps = wdata[PS_LSB +: PS_W];
                    end
                    if (strb[0]) d.win = wdata[WIN_BIT];
                    key_hit = (strb[3:2] == 2'b11) && (wdata[31:16] == WDT_KEY);
                end
                SEL_CLR: begin
                    if (wdata[EN_BIT])  d.en  = 1'b0;
                    if (wdata[WIN_BIT]) d.win = 1'b0;
                    d.ps = q.ps & ~wdata[PS_LSB +: PS_W];
                end
                SEL_SET: begin
                    if (wdata[EN_BIT])  d.en  = 1'b1;
                    if (wdata[WIN_BIT]) d.win = 1'b1;
                    d.ps = q.ps | wdata[PS_LSB +: PS_W];
                end
                default: begin
                    if (strb[0] && wdata[FLAG_BIT]) d.flag = 1'b0;
                end
            endcase
        end
        if (timeout_evt) d.flag = 1'b1;
        d.blank = q.en && !d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (!q.blank) begin
            if (sel == SEL_CAUSE) begin
                rdata[FLAG_BIT] = q.flag;
            end else begin
                rdata[EN_BIT]              = q.en;
                rdata[PS_LSB +: PS_W]      = q.ps;
                rdata[ID_LSB +: 2]         = src_id;
                rdata[WIN_BIT]             = q.win;
            end
        end
    end

    assign en   = q.en;
    assign win  = q.win;
    assign ps   = q.ps;
    assign flag = q.flag;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int PS_W  = 5,
    parameter int PRE_W = 5,
    localparam int CW   = 2 ** PS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            win,
    input  logic [PS_W-1:0] ps,
    input  logic            key_hit,
    output logic            timeout_evt,
    output logic            rst_req,
    output logic [PRE_W-1:0] pre_cnt,
    output logic [CW-1:0]   post_cnt
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CW-1:0]    post;
        logic             req;
    } cnt_state_t;

    cnt_state_t q, d;
    logic [CW:0] term;
    logic [CW:0] quarter;
    logic [CW:0] post_ext;
    logic        win_open;

    assign term     = (CW+1)'(1) << ps;
    assign quarter  = term >> 2;
    assign post_ext = {1'b0, q.post};
    assign win_open = (quarter == '0) || (post_ext >= term - quarter);

    always_comb begin
        d           = q;
        d.req       = 1'b0;
        timeout_evt = 1'b0;
        if (!en) begin
            d.pre  = '0;
            d.post = '0;
        end else if (key_hit) begin
            d.pre  = '0;
            d.post = '0;
            if (win && !win_open) begin
                timeout_evt = 1'b1;
                d.req       = 1'b1;
            end
        end else if (&q.pre) begin
            d.pre = '0;
            if (post_ext + 1'b1 >= term) begin
                d.post      = '0;
                timeout_evt = 1'b1;
                d.req       = 1'b1;
            end else begin
                d.post = q.post + 1'b1;
            end
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rst_req  = q.req;
    assign pre_cnt  = q.pre;
    assign post_cnt = q.post;
endmodule

// File: rtl/wdt_key_timer.sv
module wdt_key_timer #(
    parameter int PS_W  = 5,
    parameter int PRE_W = 5,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    clk_src_id,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_strb,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          wdt_rst_req
);
    localparam int CW = 2 ** PS_W;

    logic            ctl_en;
    logic            ctl_win;
    logic [PS_W-1:0] ctl_ps;
    logic            cause_flag;
    logic            key_hit;
    logic            timeout_evt;
    logic [PRE_W-1:0] pre_cnt;
    logic [CW-1:0]   post_cnt;

    wdt_regs #(.PS_W(PS_W), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (bus_we),
        .addr        (bus_addr),
        .strb        (bus_strb),
        .wdata       (bus_wdata),
        .src_id      (clk_src_id),
        .timeout_evt (timeout_evt),
        .rdata       (bus_rdata),
        .en          (ctl_en),
        .win         (ctl_win),
        .ps          (ctl_ps),
        .flag        (cause_flag),
        .key_hit     (key_hit)
    );

    wdt_counter #(.PS_W(PS_W), .PRE_W(PRE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctl_en),
        .win         (ctl_win),
        .ps          (ctl_ps),
        .key_hit     (key_hit),
        .timeout_evt (timeout_evt),
        .rst_req     (wdt_rst_req),
        .pre_cnt     (pre_cnt),
        .post_cnt    (post_cnt)
    );
endmodule

// File: rtl/wdt_key_timer_chk.sv
module wdt_key_timer_chk #(
    parameter int PS_W  = 5,
    parameter int PRE_W = 5,
    localparam int CW   = 2 ** PS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_en,
    input logic             ctl_win,
    input logic [PS_W-1:0]  ctl_ps,
    input logic             cause_flag,
    input logic             key_hit,
    input logic             timeout_evt,
    input logic             rst_req,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [CW-1:0]    post_cnt
);
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && $past(!ctl_en)) |-> (pre_cnt == '0 && post_cnt == '0));

    p_evt_to_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> rst_req);

    p_key_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && ctl_en && !ctl_win) |=> (pre_cnt == '0 && post_cnt == '0 && !rst_req));

    p_flag_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cause_flag);

    p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_en) |=> (!ctl_en && $stable(ctl_ps) && $stable(ctl_win)));
endmodule

bind wdt_key_timer wdt_key_timer_chk #(.PS_W(PS_W), .PRE_W(PRE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_en      (ctl_en),
    .ctl_win     (ctl_win),
    .ctl_ps      (ctl_ps),
    .cause_flag  (cause_flag),
    .key_hit     (key_hit),
    .timeout_evt (timeout_evt),
    .rst_req     (wdt_rst_req),
    .pre_cnt     (pre_cnt),
    .post_cnt    (post_cnt)
);

// File: tb/test_wdt_key_timer.sv
`timescale 1ns/1ps
module test_wdt_key_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_src_id = 2'b10;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt_key_timer i_wdt_key_timer (
        .clk(clk), .rst_n(rst_n), .clk_src_id(clk_src_id),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_strb(bus_strb),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
    );

    function automatic logic [31:0] ctrl_word(bit en, int ps, bit win);
        return {16'h0, en, 2'b00, 5'(ps), clk_src_id, 5'b0, win};
    endfunction

    function automatic int period(int ps);
        return 32 << ps;
    endfunction

    task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    // called at a falling edge; the write is captured by the next rising edge
    task automatic wr(logic [3:0] a, logic [3:0] s, logic [31:0] v);
        bus_we = 1'b1; bus_addr = a; bus_strb = s; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0; bus_strb = '0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    // caller stands right after the reference edge; pulse is due after edge n
    task automatic expect_pulse(int n, string rq);
        bit early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_req) early = 1;
        end
        chk({rq, " no early pulse"}, 32'(early), 32'd0);
        @(negedge clk);
        chk({rq, " pulse at terminal"}, 32'(wdt_rst_req), 32'd1);
    endtask

    task automatic disable_wdt();
        wr(4'h4, 4'h0, 32'h0000_9F01);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        bit seen;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R7 reset state
        rd(4'h0, v); chk("R1 ctrl reset", v, ctrl_word(0, 0, 0));
        chk("R7 clock id bits", v[7:6], 32'(2'b10));
        rd(4'hC, v); chk("R1 cause reset", v, 32'h0);
        chk("R1 no request", 32'(wdt_rst_req), 32'd0);

        // R10 direct field write, R7 id not writable
        wr(4'h0, 4'b0011, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R10 field write", v, ctrl_word(1, 31, 1));
        // R6 clear alias then R8 blank cycle
        wr(4'h4, 4'h0, 32'h0000_9F01);
        rd(4'h8, v); chk("R8 read blanked", v, 32'h0);
        wr(4'h8, 4'hF, 32'h0000_8301);
        rd(4'h0, v); chk("R8 write ignored", v, ctrl_word(0, 0, 0));

        // R6 set alias touches only 1 bits, strobes ignored
        wr(4'h8, 4'h0, 32'h0000_0201);
        wr(4'h8, 4'h0, 32'h0000_0100);
        rd(4'h0, v); chk("R6 set alias", v, ctrl_word(0, 3, 1));
        wr(4'h4, 4'h0, 32'h0000_0201);
        rd(4'h0, v); chk("R6 clear alias", v, ctrl_word(0, 1, 0));

        // R2 disabled: no request over a long stretch
        wr(4'h0, 4'b0011, 32'h0000_0000);
        seen = 0;
        repeat (200) begin @(negedge clk); if (wdt_rst_req) seen = 1; end
        chk("R2 disabled no pulse", 32'(seen), 32'd0);

        // R3 directed periods, two in a row, with R5 flag handling
        for (int ps = 0; ps < 3; ps++) begin
            wr(4'h0, 4'b0011, 32'h8000 | (ps << 8));
            expect_pulse(period(ps), "R3");
            rd(4'hC, v); chk("R5 flag set", v, 32'h10);
            expect_pulse(period(ps), "R3 restart");
            @(negedge clk);
            chk("R3 single cycle", 32'(wdt_rst_req), 32'd0);
            wr(4'hC, 4'h1, 32'h10);
            rd(4'hC, v); chk("R5 flag cleared", v, 32'h0);
            disable_wdt();
        end

        // R4 key restarts the count
        wr(4'h0, 4'b0011, 32'h0000_8100);
        repeat (40) @(negedge clk);
        wr(4'h0, 4'b1100, 32'h5743_0000);
        expect_pulse(period(1), "R4 key restart");

        // R4 random non-key values do not disturb the count
        for (int it = 0; it < 8; it++) begin
            int ps = $urandom % 4;
            int off = $urandom % (period(ps) - 2);
            logic [15:0] junk = 16'($urandom);
            logic [3:0] a = ($urandom % 2) ? 4'h0 : 4'h8;
            if (junk == 16'h5743) junk = 16'h5742;
            if (a == 4'h8) junk = 16'h5743;
            disable_wdt();
            wr(4'h0, 4'b0011, 32'h8000 | (ps << 8));
            repeat (off) @(negedge clk);
            wr(a, 4'b1100, {junk, 16'h0});
            expect_pulse(period(ps) - off - 1, "R4 ignored value");
        end
        disable_wdt();
        wr(4'hC, 4'h1, 32'h10);

        // R9 windowed clear with ps=2 (window from 96 cycles)
        wr(4'h0, 4'b0011, 32'h0000_8201);
        repeat (10) @(negedge clk);
        wr(4'h0, 4'b1100, 32'h5743_0000);
        chk("R9 early key pulse", 32'(wdt_rst_req), 32'd1);
        rd(4'hC, v); chk("R9 early key flag", v, 32'h10);
        repeat (99) @(negedge clk);
        wr(4'h0, 4'b1100, 32'h5743_0000);
        chk("R9 in-window key no pulse", 32'(wdt_rst_req), 32'd0);
        expect_pulse(period(2), "R9 after in-window key");
        disable_wdt();

        // R9 small ps: window always open
        wr(4'h0, 4'b0011, 32'h0000_8101);
        @(negedge clk);
        wr(4'h0, 4'b1100, 32'h5743_0000);
        chk("R9 ps<2 open window", 32'(wdt_rst_req), 32'd0);
        disable_wdt();

        finish_run();
    end
endmodule